// File: doc/BRIEF.md
# Parallel Uniform Crossover Unit

This block recombines two candidate solutions of a two-way circuit partitioning problem. Each solution is a bit vector with one bit per cell, where the bit value names the side of the cut that the cell sits on. On every cycle in which a parent pair is presented, the block builds a random mask. It then forms two complementary offspring by exchanging parent bits wherever the mask is set. Every cell position is handled at once, so the unit can sit inside a pipelined generation loop and take a new pair on every clock.

The random mask comes from an internal 32-bit shift register with linear feedback. When the solution is wider than 32 bits, several successive register states are placed side by side to cover it. The register moves forward only when a pair is accepted. It can be reseeded through a load port, and a zero seed is replaced by a fixed nonzero constant so that the generator cannot stall. Parent selection, repair of partition balance and fitness scoring are handled by other blocks.

Top module: `uxover_top`

## Requirements
- R1: After reset, outValid is 0, both children are all zeros, and the generator state equals the parameter SEED_DEFAULT.
- R2: For each bit i of an accepted pair with mask bit m[i]: when m[i]=1, childA[i]=parentB[i] and childB[i]=parentA[i]. When m[i]=0, childA[i]=parentA[i] and childB[i]=parentB[i]. Bits where the parents agree therefore pass to both children unchanged.
- R3: The children of a pair accepted at clock edge n appear at edge n, and outValid is 1 for exactly the cycle that follows that edge. outValid is 0 after any edge at which inValid was 0.
- R4: While inValid is 0, childA and childB hold their last values, whatever the parents and the seed port are doing.
- R5: One generator step maps state s to {s[30:0], s[31]^s[21]^s[1]^s[0]} (a left shift with the feedback entering bit 0).
- R6: The mask bits [32k+31:32k] equal the current state stepped k times, with k = 0, 1, ... and the top chunk truncated to WIDTH. After each accepted pair without a seed load, the state moves forward ceil(WIDTH/32) steps. Otherwise it holds.
- R7: When seedLoad is 1 at an edge, the state becomes seedValue, or SEED_DEFAULT if seedValue is zero.
- R8: When seedLoad and inValid are both 1 at the same edge, the pair uses the mask of the state before the load. The state then takes the seed without stepping.
- R9: A new pair can be accepted on every cycle, and each pair sees a fresh mask.
- R10: The generator state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A parent pair is presented this cycle |
| parentA | input | WIDTH | First parent, one bit per cell |
| parentB | input | WIDTH | Second parent, one bit per cell |
| seedLoad | input | 1 | Load the generator state from seedValue |
| seedValue | input | 32 | New generator state (zero selects SEED_DEFAULT) |
| outValid | output | 1 | Children are new this cycle |
| childA | output | WIDTH | Offspring that starts from parentA |
| childB | output | WIDTH | Offspring that starts from parentB |

## Verification
The bench builds the unit with WIDTH = 80. Because 80 is not a multiple of 32, the mask is made from three generator steps and the last one is cut to 16 bits, which tests both the chaining of chunks and the truncation of the top chunk. Driving parentA to zeros and parentB to ones makes childA equal to the raw mask. This lets the bench check the step rule, the default seed, zero-seed substitution and the ordering of a seed load against a pair accepted at the same edge, all from the ports alone.

// File: rtl/xover_pkg.sv
package xover_pkg;

  localparam int unsigned LFSR_W = 32;

  typedef struct packed {
    logic capture;
    logic advance;
    logic loadSeed;
  } xoverStrobes_t;

  function automatic logic [LFSR_W-1:0] lfsrStep(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

endpackage

// File: rtl/xover_ctrl.sv
module xover_ctrl
  import xover_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          seedLoad,
  output xoverStrobes_t strobes,
  output logic          outValid
);

  always_comb begin
    strobes.capture  = inValid;
    strobes.loadSeed = seedLoad;
    strobes.advance  = inValid & ~seedLoad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R3
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R3

endmodule

// File: rtl/xover_mask.sv
module xover_mask
  import xover_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter logic [31:0] SEED_DEFAULT = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rstN,
  input  xoverStrobes_t     strobes,
  input  logic [LFSR_W-1:0] seedValue,
  output logic [WIDTH-1:0]  mask
);

  localparam int unsigned NSTEP = (WIDTH + LFSR_W - 1) / LFSR_W;

  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] chain [NSTEP+1];

  assign chain[0] = state;

  for (genvar k = 0; k < NSTEP; k++) begin : g_chunk
    localparam int unsigned LO = k * LFSR_W;
    localparam int unsigned HI = ((LO + LFSR_W) > WIDTH) ? WIDTH - 1 : LO + LFSR_W - 1;
    assign chain[k+1]  = lfsrStep(chain[k]);
    assign mask[HI:LO] = chain[k][HI-LO:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SEED_DEFAULT;
    end else if (strobes.loadSeed) begin
      state <= (seedValue == '0) ? SEED_DEFAULT : seedValue;
    end else if (strobes.advance) begin
      state <= chain[NSTEP];
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    state != '0); // R10
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.advance || strobes.loadSeed) |=> $stable(state)); // R6
  AST_SEED_ZERO_SUB: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSeed && seedValue == '0) |=> state == SEED_DEFAULT); // R7
  AST_SEED_TAKEN: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadSeed && seedValue != '0) |=> state == $past(seedValue)); // R7

endmodule

// File: rtl/xover_datapath.sv
module xover_datapath
  import xover_pkg::*;
#(
  parameter int unsigned WIDTH = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  xoverStrobes_t    strobes,
  input  logic [WIDTH-1:0] parA,
  input  logic [WIDTH-1:0] parB,
  input  logic [WIDTH-1:0] mask,
  output logic [WIDTH-1:0] childA,
  output logic [WIDTH-1:0] childB
);

  logic [WIDTH-1:0] mixA;
  logic [WIDTH-1:0] mixB;

  always_comb begin
    mixA = (parA & ~mask) | (parB & mask);
    mixB = (parB & ~mask) | (parA & mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      childA <= '0;
      childB <= '0;
    end else if (strobes.capture) begin
      childA <= mixA;
      childB <= mixB;
    end
  end

  AST_CHILD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(childA) && $stable(childB))); // R4
  AST_DIFF_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ((childA ^ childB) == $past(parA ^ parB))); // R2
  AST_AGREE_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> ((childA & childB) == $past(parA & parB))); // R2

endmodule

// File: rtl/uxover_top.sv
module uxover_top
  import xover_pkg::*;
#(
  parameter int unsigned WIDTH = 64,
  parameter logic [31:0] SEED_DEFAULT = 32'h1D87_2B41
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [WIDTH-1:0] parentA,
  input  logic [WIDTH-1:0] parentB,
  input  logic             seedLoad,
  input  logic [31:0]      seedValue,
  output logic             outValid,
  output logic [WIDTH-1:0] childA,
  output logic [WIDTH-1:0] childB
);

  xoverStrobes_t    strobes;
  logic [WIDTH-1:0] mask;

  xover_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .seedLoad (seedLoad),
    .strobes  (strobes),
    .outValid (outValid)
  );

  xover_mask #(.WIDTH(WIDTH), .SEED_DEFAULT(SEED_DEFAULT)) u_mask (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .seedValue (seedValue),
    .mask      (mask)
  );

  xover_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .parA    (parentA),
    .parB    (parentB),
    .mask    (mask),
    .childA  (childA),
    .childB  (childB)
  );

endmodule

// File: tb/tb_uxover_top.sv
`timescale 1ns/1ps
module tb_uxover_top;

  localparam int unsigned W = 80;
  localparam logic [31:0] SEED_DEF = 32'h1D87_2B41;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [W-1:0] parentA = '0;
  logic [W-1:0] parentB = '0;
  logic seedLoad = 1'b0;
  logic [31:0] seedValue = '0;
  logic outValid;
  logic [W-1:0] childA, childB;

  always #2.5 clk = ~clk;

  uxover_top #(.WIDTH(W), .SEED_DEFAULT(SEED_DEF)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .parentA(parentA), .parentB(parentB),
    .seedLoad(seedLoad), .seedValue(seedValue), .outValid(outValid),
    .childA(childA), .childB(childB)
  );

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    int unsigned  stamp;
    string        req;
  } expItem_t;

  expItem_t     sb[$];
  int unsigned  checks = 0;
  int unsigned  errors = 0;
  int unsigned  cycleCount = 0;
  logic [31:0]  mState = SEED_DEF;
  logic [W-1:0] lastA = '0;
  logic [W-1:0] lastB = '0;
  bit           running = 0;
  bit           done = 0;

  function automatic logic [31:0] stepB(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  function automatic logic [95:0] wideMask(input logic [31:0] s);
    logic [95:0] m;
    logic [31:0] c;
    c = s;
    for (int k = 0; k < 3; k++) begin
      m[k*32 +: 32] = c;
      c = stepB(c);
    end
    return m;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // driver: presents one cycle of stimulus and pushes the expected children
  task automatic drive(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic sl, input logic [31:0] sv, input string req);
    logic [95:0] wm;
    logic [W-1:0] m;
    expItem_t it;
    @(negedge clk);
    inValid = v; parentA = a; parentB = b; seedLoad = sl; seedValue = sv;
    wm = wideMask(mState);
    m = wm[W-1:0];
    if (v) begin
      it.a = (a & ~m) | (b & m);
      it.b = (b & ~m) | (a & m);
      it.stamp = cycleCount + 1;
      it.req = req;
      sb.push_back(it);
    end
    if (sl)     mState = (sv == '0) ? SEED_DEF : sv;
    else if (v) mState = stepB(stepB(stepB(mState)));
  endtask

  function automatic logic [W-1:0] rnd();
    return W'({$urandom, $urandom, $urandom});
  endfunction

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 20000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=<20000", cycleCount);
      summary();
      $finish;
    end
  end

  // monitor: compares outputs against the scoreboard
  always @(negedge clk) begin
    if (running) begin
      if (outValid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "outValid without pending pair", W'(1), W'(0));
        end else begin
          expItem_t e;
          e = sb.pop_front();
          check(e.stamp == cycleCount, "R3", "latency", W'(cycleCount), W'(e.stamp));
          check(childA == e.a, e.req, "childA", childA, e.a);
          check(childB == e.b, e.req, "childB", childB, e.b);
          lastA = e.a;
          lastB = e.b;
        end
      end else begin
        check(childA == lastA && childB == lastB, "R4", "hold while idle", childA, lastA);
      end
    end
  end

  initial begin
    logic [W-1:0] ones;
    logic [W-1:0] x;
    ones = '1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(outValid == 1'b0, "R1", "outValid", W'(outValid), W'(0));
    check(childA == '0 && childB == '0, "R1", "children", childA, '0);
    running = 1;
    // R1 R5 R6: raw mask from the default seed
    drive(1, '0, ones, 0, '0, "R1_R6");
    drive(1, '0, ones, 0, '0, "R5_R6");
    // R2 R9: back-to-back random pairs
    for (int i = 0; i < 10; i++) drive(1, rnd(), rnd(), 0, '0, "R2_R9");
    // R2: identical parents pass unchanged
    x = rnd();
    drive(1, x, x, 0, '0, "R2");
    // R4: idle with changing parents and no seed load
    for (int i = 0; i < 4; i++) drive(0, rnd(), rnd(), 0, '0, "R4");
    // R7: seed load alone, then reveal mask
    drive(0, rnd(), rnd(), 1, 32'h1234_5678, "R7");
    drive(1, '0, ones, 0, '0, "R7");
    // R7 R10: zero seed substitutes the default
    drive(0, '0, '0, 1, 32'h0, "R7");
    drive(1, '0, ones, 0, '0, "R7_R10");
    // R8: seed load and pair at the same edge
    drive(0, '0, '0, 1, 32'hCAFE_0F0F, "R8");
    drive(1, '0, ones, 1, 32'h0BAD_5EED, "R8");
    drive(1, '0, ones, 0, '0, "R8");
    drive(1, ones, '0, 0, '0, "R2_R6");
    for (int i = 0; i < 6; i++) drive(1, rnd(), rnd(), 0, '0, "R2_R9");
    drive(0, '0, '0, 0, '0, "R3");
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R3", "pending pairs left", W'(sb.size()), W'(0));
    done = 1;
    summary();
    $finish;
  end

endmodule